// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every processor access, what the addressed memory allows. Software programs eight regions, each with its own base address, power-of-two span and enable. Two packed permission words give each region a 4-bit data-access code and a 4-bit code-access code. Three per-region bit vectors mark regions as data-cacheable, write-back and instruction-cacheable. For each access the block takes an address, a privilege flag and an access kind. It returns six attribute flags: read, write, execute, data-cacheable, write-back and instruction-cacheable.

The attribute lookup is combinational from the stored configuration, so the flags are valid in the same cycle as the address. A registered abort pulse follows one cycle after a data read or data write that the resolved rights forbid. A global control word can switch protection off. In that case every address is fully accessible, and cacheability follows the two cache enable bits.

Top module: `prot_region_unit`

## Requirements
- R1: After reset all configuration is zero, so protection is off: read, write and execute are 1, the three cache flags are 0, and the abort output is 0.
- R2: While control bit 0 (protection enable) is 0, every address gets read, write and execute. Data-cacheable and write-back both equal control bit 2. Instruction-cacheable equals control bit 12.
- R3: While protection is enabled, an address that no enabled region covers gets all six flags at 0.
- R4: A region covers the 4 KiB pages from its base page (register bits 31:12) up to, but not including, base plus (2 << S) bytes, where S is register bits 5:1. Bit 0 enables the region. A span below 4 KiB (S < 11) covers no page.
- R5: The data code of region n is bits [4n+3:4n] of the data permission word. Privileged rights are: codes 1, 2 and 3 give read and write; codes 5 and 6 give read only. User rights are: code 2 gives read, code 3 gives read and write, code 6 gives read. Every other code gives nothing.
- R6: The code-access code of region n is bits [4n+3:4n] of the code permission word. Privileged execute is granted for codes 1, 2, 3, 5 and 6. User execute is granted for codes 2, 3 and 6.
- R7: For a covered address, data-cacheable is the region's data-cacheable bit. Write-back is that bit ANDed with the region's write-back bit. Instruction-cacheable is the region's instruction-cacheable bit.
- R8: When several enabled regions cover an address, the region with the highest index decides all six flags.
- R9: Access kind encoding is 0 none, 1 data read, 2 data write, 3 fetch. The abort output is 1 in the cycle after a read that lacks read rights or a write that lacks write rights. It is 0 after any other cycle, including fetches.
- R10: A write with select s stores the data at the clock edge. s = 0 to 7 writes the register of region s. s = 8 writes the control word, 9 the data permission word and 10 the code permission word. s = 11, 12 and 13 write the data-cacheable, write-back and instruction-cacheable vectors from data bits 7:0. The new value governs accesses from the next cycle on; an access in the write cycle still sees the old value.
- R11: Writes with select 14 or 15 change nothing. A region whose enable bit is 0 has no effect on any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | 1 = privileged access, 0 = user |
| acc_kind | input | 2 | Access kind (none, read, write, fetch) |
| attr_rd | output | 1 | Read permitted |
| attr_wr | output | 1 | Write permitted |
| attr_ex | output | 1 | Execute permitted |
| attr_dcache | output | 1 | Data-cacheable |
| attr_wback | output | 1 | Write-back |
| attr_icache | output | 1 | Instruction-cacheable |
| abort_o | output | 1 | Access-denied pulse, one cycle after the access |

## Verification
A configuration write and a denied-or-permitted data access can land in the same cycle. The bench provokes this by presenting a privileged read of a region while writing a permission word that revokes that read at the same edge. The abort in the next cycle must reflect the old, permitting code. The attributes visible in that next cycle, and the abort one cycle later, must reflect the new, denying code.

// File: rtl/prot_pkg.sv
package prot_pkg;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_DC_BIT = 2;
  localparam int CTRL_IC_BIT = 12;
  localparam int CODE_W      = 4;
  localparam int SIZE_W      = 5;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_FETCH = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic dc;
    logic wb;
    logic ic;
  } attr_t;

  // returns {read, write}
  function automatic logic [1:0] data_rights(input logic [CODE_W-1:0] code, input logic priv);
    logic [1:0] r;
    r = 2'b00;
    if (priv) begin
      unique case (code)
        4'd1, 4'd2, 4'd3: r = 2'b11;
        4'd5, 4'd6:       r = 2'b10;
        default:          r = 2'b00;
      endcase
    end else begin
      unique case (code)
        4'd2, 4'd6: r = 2'b10;
        4'd3:       r = 2'b11;
        default:    r = 2'b00;
      endcase
    end
    return r;
  endfunction

  function automatic logic exec_right(input logic [CODE_W-1:0] code, input logic priv);
    logic x;
    unique case (code)
      4'd2, 4'd3, 4'd6: x = 1'b1;
      4'd1, 4'd5:       x = priv;
      default:          x = 1'b0;
    endcase
    return x;
  endfunction

endpackage

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs #(
  parameter int NREGION   = 8,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 12,
  parameter int SEL_W     = 4,
  localparam int PG_W     = ADDR_W - PAGE_LOG2,
  localparam int PERM_W   = prot_pkg::CODE_W * NREGION
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we,
  input  logic [SEL_W-1:0]                        sel,
  input  logic [ADDR_W-1:0]                       wdata,
  output logic [NREGION-1:0]                      rgn_en,
  output logic [NREGION-1:0][prot_pkg::SIZE_W-1:0] rgn_sz,
  output logic [NREGION-1:0][PG_W-1:0]            rgn_base,
  output logic [2:0]                              ctrl_q,
  output logic [PERM_W-1:0]                       dperm,
  output logic [PERM_W-1:0]                       cperm,
  output logic [NREGION-1:0]                      dc_vec,
  output logic [NREGION-1:0]                      wb_vec,
  output logic [NREGION-1:0]                      ic_vec
);
  import prot_pkg::*;

  localparam int SEL_CTRL  = NREGION;
  localparam int SEL_DPERM = NREGION + 1;
  localparam int SEL_CPERM = NREGION + 2;
  localparam int SEL_DC    = NREGION + 3;
  localparam int SEL_WB    = NREGION + 4;
  localparam int SEL_IC    = NREGION + 5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgn_en   <= '0;
      rgn_sz   <= '0;
      rgn_base <= '0;
      ctrl_q   <= '0;
      dperm    <= '0;
      cperm    <= '0;
      dc_vec   <= '0;
      wb_vec   <= '0;
      ic_vec   <= '0;
    end else if (we) begin
      for (int i = 0; i < NREGION; i++) begin
        if (sel == SEL_W'(i)) begin
          rgn_en[i]   <= wdata[0];
          rgn_sz[i]   <= wdata[SIZE_W:1];
          rgn_base[i] <= wdata[ADDR_W-1:PAGE_LOG2];
        end
      end
      if (sel == SEL_W'(SEL_CTRL))
        ctrl_q <= {wdata[CTRL_IC_BIT], wdata[CTRL_DC_BIT], wdata[CTRL_EN_BIT]};
      if (sel == SEL_W'(SEL_DPERM)) dperm  <= wdata[PERM_W-1:0];
      if (sel == SEL_W'(SEL_CPERM)) cperm  <= wdata[PERM_W-1:0];
      if (sel == SEL_W'(SEL_DC))    dc_vec <= wdata[NREGION-1:0];
      if (sel == SEL_W'(SEL_WB))    wb_vec <= wdata[NREGION-1:0];
      if (sel == SEL_W'(SEL_IC))    ic_vec <= wdata[NREGION-1:0];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata[PAGE_LOG2-1:SIZE_W+1];

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match #(
  parameter int NREGION   = 8,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 12,
  localparam int PG_W     = ADDR_W - PAGE_LOG2
) (
  input  logic [PG_W-1:0]                         page,
  input  logic [NREGION-1:0]                      rgn_en,
  input  logic [NREGION-1:0][prot_pkg::SIZE_W-1:0] rgn_sz,
  input  logic [NREGION-1:0][PG_W-1:0]            rgn_base,
  output logic [NREGION-1:0]                      hit
);

  // number of whole pages covered by a span of (2 << sz) bytes
  function automatic logic [PG_W:0] span_pages(input logic [prot_pkg::SIZE_W-1:0] sz);
    int e;
    e = int'(sz) + 1 - PAGE_LOG2;
    if (e < 0) return '0;
    return {{PG_W{1'b0}}, 1'b1} << e;
  endfunction

  function automatic logic page_in(input logic [PG_W-1:0] pg, input logic [PG_W-1:0] base,
                                   input logic [prot_pkg::SIZE_W-1:0] sz);
    logic [PG_W:0] lo, hi, p;
    p  = {1'b0, pg};
    lo = {1'b0, base};
    hi = lo + span_pages(sz);
    return (p >= lo) && (p < hi);
  endfunction

  for (genvar g = 0; g < NREGION; g++) begin : g_rgn
    assign hit[g] = rgn_en[g] && page_in(page, rgn_base[g], rgn_sz[g]);
  end

endmodule

// File: rtl/prot_attr_resolve.sv
module prot_attr_resolve #(
  parameter int NREGION = 8,
  localparam int IDX_W  = $clog2(NREGION),
  localparam int PERM_W = prot_pkg::CODE_W * NREGION
) (
  input  logic [NREGION-1:0] hit,
  input  logic [PERM_W-1:0]  dperm,
  input  logic [PERM_W-1:0]  cperm,
  input  logic [NREGION-1:0] dc_vec,
  input  logic [NREGION-1:0] wb_vec,
  input  logic [NREGION-1:0] ic_vec,
  input  logic               prot_en,
  input  logic               ctrl_dc,
  input  logic               ctrl_ic,
  input  logic               priv,
  output prot_pkg::attr_t    attr,
  output logic               any_hit
);
  import prot_pkg::*;

  logic [IDX_W-1:0]  win;
  logic [CODE_W-1:0] dcode, ccode;
  logic [1:0]        drw;

  // later (higher) index overrides earlier ones
  always_comb begin
    win = '0;
    for (int i = 0; i < NREGION; i++)
      if (hit[i]) win = IDX_W'(i);
  end

  assign any_hit = |hit;
  assign dcode   = dperm[CODE_W*win +: CODE_W];
  assign ccode   = cperm[CODE_W*win +: CODE_W];
  assign drw     = data_rights(dcode, priv);

  always_comb begin
    if (!prot_en) begin
      attr = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, dc: ctrl_dc, wb: ctrl_dc, ic: ctrl_ic};
    end else if (!any_hit) begin
      attr = '0;
    end else begin
      attr.rd = drw[1];
      attr.wr = drw[0];
      attr.ex = exec_right(ccode, priv);
      attr.dc = dc_vec[win];
      attr.wb = dc_vec[win] & wb_vec[win];
      attr.ic = ic_vec[win];
    end
  end

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit #(
  parameter int NREGION   = 8,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 12,
  localparam int SEL_W    = $clog2(NREGION + 6),
  localparam int PG_W     = ADDR_W - PAGE_LOG2,
  localparam int PERM_W   = prot_pkg::CODE_W * NREGION
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  input  logic [1:0]        acc_kind,
  output logic              attr_rd,
  output logic              attr_wr,
  output logic              attr_ex,
  output logic              attr_dcache,
  output logic              attr_wback,
  output logic              attr_icache,
  output logic              abort_o
);
  import prot_pkg::*;

  logic [NREGION-1:0]              rgn_en;
  logic [NREGION-1:0][SIZE_W-1:0]  rgn_sz;
  logic [NREGION-1:0][PG_W-1:0]    rgn_base;
  logic [2:0]                      ctrl_q;
  logic [PERM_W-1:0]               dperm, cperm;
  logic [NREGION-1:0]              dc_vec, wb_vec, ic_vec;
  logic [NREGION-1:0]              hit;
  logic                            any_hit;
  logic                            prot_en;
  logic                            denied;
  attr_t                           attr;

  prot_cfg_regs #(.NREGION(NREGION), .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rgn_en(rgn_en), .rgn_sz(rgn_sz), .rgn_base(rgn_base), .ctrl_q(ctrl_q),
    .dperm(dperm), .cperm(cperm), .dc_vec(dc_vec), .wb_vec(wb_vec), .ic_vec(ic_vec)
  );

  prot_region_match #(.NREGION(NREGION), .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u_match (
    .page(acc_addr[ADDR_W-1:PAGE_LOG2]), .rgn_en(rgn_en), .rgn_sz(rgn_sz),
    .rgn_base(rgn_base), .hit(hit)
  );

  assign prot_en = ctrl_q[0];

  prot_attr_resolve #(.NREGION(NREGION)) u_resolve (
    .hit(hit), .dperm(dperm), .cperm(cperm), .dc_vec(dc_vec), .wb_vec(wb_vec),
    .ic_vec(ic_vec), .prot_en(prot_en), .ctrl_dc(ctrl_q[1]), .ctrl_ic(ctrl_q[2]),
    .priv(acc_priv), .attr(attr), .any_hit(any_hit)
  );

  assign attr_rd     = attr.rd;
  assign attr_wr     = attr.wr;
  assign attr_ex     = attr.ex;
  assign attr_dcache = attr.dc;
  assign attr_wback  = attr.wb;
  assign attr_icache = attr.ic;

  assign denied = ((acc_kind == KIND_READ)  && !attr.rd) ||
                  ((acc_kind == KIND_WRITE) && !attr.wr);

  always_ff @(posedge clk) begin
    if (!rst_n) abort_o <= 1'b0;
    else        abort_o <= denied;
  end

  logic unused_addr_lo;
  assign unused_addr_lo = ^acc_addr[PAGE_LOG2-1:0];

endmodule

// File: rtl/prot_checker.sv
module prot_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] acc_kind,
  input logic       attr_rd,
  input logic       attr_wr,
  input logic       attr_ex,
  input logic       attr_dcache,
  input logic       attr_wback,
  input logic       attr_icache,
  input logic       abort_o,
  input logic       prot_en,
  input logic       any_hit,
  input logic       cfg_we,
  input logic [2:0] ctrl_q
);

  a_r9_denied_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd1 && !attr_rd) |=> abort_o);

  a_r9_denied_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd2 && !attr_wr) |=> abort_o);

  a_r9_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd3 || acc_kind == 2'd0) |=> !abort_o);

  a_r2_off_full: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (attr_rd && attr_wr && attr_ex));

  a_r3_nohit_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && !any_hit) |-> !(attr_rd || attr_wr || attr_ex || attr_dcache || attr_wback || attr_icache));

  a_r7_wb_needs_dc: assert property (@(posedge clk) disable iff (!rst_n)
    attr_wback |-> attr_dcache);

  a_r10_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctrl_q));

endmodule

bind prot_region_unit prot_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind),
  .attr_rd(attr_rd), .attr_wr(attr_wr), .attr_ex(attr_ex),
  .attr_dcache(attr_dcache), .attr_wback(attr_wback), .attr_icache(attr_icache),
  .abort_o(abort_o), .prot_en(prot_en), .any_hit(any_hit),
  .cfg_we(cfg_we), .ctrl_q(ctrl_q)
);

// File: tb/sim_prot_region_unit.sv
`timescale 1ns/1ps
module sim_prot_region_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b1;
  logic [1:0]  acc_kind = 2'd0;
  logic        attr_rd, attr_wr, attr_ex, attr_dcache, attr_wback, attr_icache, abort_o;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic        done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prot_region_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
    .attr_rd(attr_rd), .attr_wr(attr_wr), .attr_ex(attr_ex), .attr_dcache(attr_dcache),
    .attr_wback(attr_wback), .attr_icache(attr_icache), .abort_o(abort_o)
  );

  wire [5:0] attrs = {attr_rd, attr_wr, attr_ex, attr_dcache, attr_wback, attr_icache};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_acc(input logic [31:0] a, input logic p, input logic [1:0] k);
    @(negedge clk);
    acc_addr = a; acc_priv = p; acc_kind = k;
    #2;
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic p, input logic [5:0] exp);
    drive_acc(a, p, 2'd0);
    chk(req, {26'd0, attrs}, {26'd0, exp});
  endtask

  task automatic expect_abort(input string req, input logic [31:0] a, input logic p,
                              input logic [1:0] k, input logic exp);
    drive_acc(a, p, k);
    @(negedge clk);
    chk(req, {31'd0, abort_o}, {31'd0, exp});
    acc_kind = 2'd0;
    @(negedge clk);
    chk(req, {31'd0, abort_o}, 32'd0);
  endtask

  // independent statement of the code tables
  function automatic logic [2:0] exp_rwx(input int code, input logic p);
    logic r, w, x;
    r = 0; w = 0; x = 0;
    if (p) begin
      if (code == 1 || code == 2 || code == 3) begin r = 1; w = 1; end
      if (code == 5 || code == 6) r = 1;
      x = (code == 1 || code == 2 || code == 3 || code == 5 || code == 6);
    end else begin
      if (code == 2 || code == 6) r = 1;
      if (code == 3) begin r = 1; w = 1; end
      x = (code == 2 || code == 3 || code == 6);
    end
    return {r, w, x};
  endfunction

  task automatic t_reset;
    look("R1", 32'h0000_0000, 1'b1, 6'b111000);
    look("R1", 32'hFFFF_F000, 1'b0, 6'b111000);
    chk("R1", {31'd0, abort_o}, 32'd0);
  endtask

  task automatic t_disabled_cache;
    cfg_write(4'd8, 32'h0000_0004);
    look("R2", 32'h1234_5000, 1'b0, 6'b111110);
    cfg_write(4'd8, 32'h0000_1000);
    look("R2", 32'h1234_5000, 1'b1, 6'b111001);
    cfg_write(4'd8, 32'h0000_1004);
    look("R2", 32'h8000_0000, 1'b1, 6'b111111);
    cfg_write(4'd8, 32'h0000_0001);
  endtask

  task automatic t_no_hit;
    look("R3", 32'h0000_0000, 1'b1, 6'b000000);
    look("R3", 32'h8000_0000, 1'b0, 6'b000000);
  endtask

  task automatic t_span;
    cfg_write(4'd9, 32'h0000_0033);
    cfg_write(4'd0, 32'h0200_002B);  // 4 MiB at 0x02000000
    cfg_write(4'd1, 32'h0300_0015);  // 2 KiB: covers no page
    look("R4", 32'h0200_0000, 1'b1, 6'b110000);
    look("R4", 32'h023F_FFFC, 1'b1, 6'b110000);
    look("R4", 32'h0240_0000, 1'b1, 6'b000000);
    look("R4", 32'h01FF_FFFC, 1'b1, 6'b000000);
    look("R4", 32'h0300_0000, 1'b1, 6'b000000);
    cfg_write(4'd1, 32'h0300_0017);  // 4 KiB: one page
    look("R4", 32'h0300_0FFC, 1'b1, 6'b110000);
    look("R4", 32'h0300_1000, 1'b1, 6'b000000);
  endtask

  task automatic t_perm;
    cfg_write(4'd2, 32'h0000_003F);  // whole space
    for (int c = 0; c < 8; c++) begin
      cfg_write(4'd9, 32'(c) << 8);
      cfg_write(4'd10, 32'(c) << 8);
      look("R5 R6 priv", 32'h1000_0000, 1'b1, {exp_rwx(c, 1'b1), 3'b000});
      look("R5 R6 user", 32'h1000_0000, 1'b0, {exp_rwx(c, 1'b0), 3'b000});
    end
  endtask

  task automatic t_cache;
    cfg_write(4'd9, 32'h0000_0300);
    cfg_write(4'd10, 32'h0000_0200);
    cfg_write(4'd11, 32'h0000_0004);
    look("R7", 32'h1000_0000, 1'b1, 6'b111100);
    cfg_write(4'd11, 32'h0000_0000);
    cfg_write(4'd12, 32'h0000_0004);
    look("R7", 32'h1000_0000, 1'b1, 6'b111000);
    cfg_write(4'd11, 32'h0000_0004);
    look("R7", 32'h1000_0000, 1'b1, 6'b111110);
    cfg_write(4'd13, 32'h0000_0004);
    look("R7", 32'h1000_0000, 1'b0, 6'b111111);
    cfg_write(4'd11, 32'h0);
    cfg_write(4'd12, 32'h0);
    cfg_write(4'd13, 32'h0);
  endtask

  task automatic t_priority;
    cfg_write(4'd9, 32'h0060_0300);
    cfg_write(4'd5, 32'h1000_0029);  // 2 MiB at 0x10000000
    look("R8", 32'h1000_0000, 1'b1, 6'b100000);
    look("R8", 32'h1020_0000, 1'b1, 6'b111000);
    cfg_write(4'd5, 32'h1000_0028);  // disabled
    look("R11 disabled region", 32'h1000_0000, 1'b1, 6'b111000);
  endtask

  task automatic t_abort;
    cfg_write(4'd5, 32'h1000_0029);
    expect_abort("R9 write denied", 32'h1000_0000, 1'b1, 2'd2, 1'b1);
    expect_abort("R9 read ok", 32'h1000_0000, 1'b1, 2'd1, 1'b0);
    expect_abort("R9 fetch", 32'h1000_0000, 1'b1, 2'd3, 1'b0);
    cfg_write(4'd9, 32'h0010_0300);
    expect_abort("R9 user read denied", 32'h1000_0000, 1'b0, 2'd1, 1'b1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'd9; cfg_wdata = 32'h0000_0300;
    acc_addr = 32'h1000_0000; acc_priv = 1'b1; acc_kind = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 old code in write cycle", {31'd0, abort_o}, 32'd0);
    chk("R10 new code next cycle", {26'd0, attrs}, 32'd0);
    @(negedge clk);
    chk("R10 abort after update", {31'd0, abort_o}, 32'd1);
    acc_kind = 2'd0;
  endtask

  task automatic t_ignored;
    cfg_write(4'd14, 32'hFFFF_FFFF);
    cfg_write(4'd15, 32'hFFFF_FFFF);
    look("R11 ignored select", 32'h1020_0000, 1'b1, 6'b111000);
    look("R11 ignored select", 32'h1000_0000, 1'b1, 6'b000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled_cache();
    t_no_hit();
    t_span();
    t_perm();
    t_cache();
    t_priority();
    t_abort();
    t_same_cycle();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule